// File: doc/BRIEF.md
# Serial Command and Display-Data Loader

This block receives a three-wire host stream made of a data line, a shift strobe and a load strobe. It turns that stream into segment patterns for four display banks and into a small set of display mode settings. All three wires come from another clock domain, so they are synchronised into the block's system clock. Each rising edge of the shift strobe, detected after synchronisation, moves one data bit into a frame register. A full frame is `SEG_W` segment bits followed by six command bits, sent C0 first and C5 last.

When the load strobe rises, the block decodes the six command bits that were shifted in last. A data-write command then copies the segment part of the frame into one of four banks, one bank per common line. The chosen bank keeps tracking the frame register while the load strobe stays high, and it holds the last value once the strobe falls. The other commands set the frame-rate code, the bias and waveform selects, the duty code or the display enable.

Only the trailing six bits are decoded. A host may therefore send a mode command on its own, with no segment bits, or put padding bits in front of a frame.

Top module: `lcd_serial_loader`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_data` into the frame register, with the last bit at the C5 end. In a full frame the first segment bit sent lands in bank bit `SEG_W-1`, and the last segment bit, sent just before C0, lands in bit 0. A bit value of 1 means the segment is on.
- R2: If opcode {C5,C4,C3} is 001, the segment bits are written into the bank whose index is {C2,C1}. The other three banks keep their contents.
- R3: Opcode 010 loads `rate_code` with {C2,C1,C0}.
- R4: Opcode 011 loads `bias_half` with C2 and `wave_b` with C1.
- R5: Opcode 100 loads `duty_code` with {C2,C1}.
- R6: Opcode 101 loads `disp_on` with C2. `disp_on` never rises except after a load-strobe rise.
- R7: Opcodes 000, 110 and 111 change no bank and no mode field. The segment bits of a frame whose opcode is not 001 never reach a bank.
- R8: The command is taken at the rising edge of `ser_load`. It uses only the six most recently shifted bits, so a frame made only of padding bits and a command sets a mode field correctly. Mode fields change at no other time.
- R9: While `ser_load` is high, the addressed bank follows the frame register. After `ser_load` falls, the bank holds its value and no bank changes while the strobe is low.
- R10: `ser_clk` edges that arrive while `ser_load` is high shift nothing.
- R11: `rst_n` low clears all banks and all mode fields to zero at once, without waiting for a clock edge. Zero means rate code 0, 1/3 bias, waveform A, static duty and display off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift strobe, sampled for rising edges |
| ser_load | input | 1 | Load strobe, command executed on its rise |
| bank0 | output | SEG_W | Segment pattern for common 1 |
| bank1 | output | SEG_W | Segment pattern for common 2 |
| bank2 | output | SEG_W | Segment pattern for common 3 |
| bank3 | output | SEG_W | Segment pattern for common 4 |
| rate_code | output | 3 | Frame-rate selection code |
| bias_half | output | 1 | 1 selects 1/2 bias, 0 selects 1/3 bias |
| wave_b | output | 1 | 1 selects waveform B, 0 waveform A |
| duty_code | output | 2 | 0 static, 1 half, 2 third, 3 quarter duty |
| disp_on | output | 1 | Display enable |

## Verification
Some rules are checked on every cycle by the assertions. Mode fields move only in the cycle after a load-strobe rise. No bank moves while the strobe is low, and at most one bank changes in any cycle. The frame register is frozen while the strobe is high. The display enable rises only after a load rise. The bench scenarios are the only way to show the rest: that the bit order and the field positions map to the right bank bits and codes, that short padded mode frames decode correctly, that ignored opcodes and non-write segment bits leave everything as it was, and that reset clears the outputs without a clock edge.

// File: rtl/lcd_serial_loader.sv
module lcd_serial_loader #(
  parameter int SEG_W = 50,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_data,
  input  logic             ser_clk,
  input  logic             ser_load,
  output logic [SEG_W-1:0] bank0,
  output logic [SEG_W-1:0] bank1,
  output logic [SEG_W-1:0] bank2,
  output logic [SEG_W-1:0] bank3,
  output logic [2:0]       rate_code,
  output logic             bias_half,
  output logic             wave_b,
  output logic [1:0]       duty_code,
  output logic             disp_on
);
  localparam int CMD_W   = 6;
  localparam int FRAME_W = SEG_W + CMD_W;
  localparam int NBANK   = 4;
  localparam logic [2:0] OP_WRITE = 3'b001;
  localparam logic [2:0] OP_RATE  = 3'b010;
  localparam logic [2:0] OP_DRIVE = 3'b011;
  localparam logic [2:0] OP_DUTY  = 3'b100;
  localparam logic [2:0] OP_DISP  = 3'b101;

  logic [SYNC_N:0] clk_p, ld_p;
  logic [SYNC_N-1:0] dat_p;
  logic clk_rise, ld_s, ld_rise, dat_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_p <= '0;
      ld_p  <= '0;
      dat_p <= '0;
    end else begin
      clk_p <= {clk_p[SYNC_N-1:0], ser_clk};
      ld_p  <= {ld_p[SYNC_N-1:0], ser_load};
      dat_p <= {dat_p[SYNC_N-2:0], ser_data};
    end
  end

  assign dat_s    = dat_p[SYNC_N-1];
  assign ld_s     = ld_p[SYNC_N-1];
  assign ld_rise  = ld_p[SYNC_N-1] & ~ld_p[SYNC_N];
  assign clk_rise = clk_p[SYNC_N-1] & ~clk_p[SYNC_N] & ~ld_s;

  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (clk_rise) sr <= {sr[FRAME_W-2:0], dat_s};
  end

  logic [2:0] op;
  logic c2, c1, c0;
  logic [SEG_W-1:0] seg;

  assign op  = {sr[0], sr[1], sr[2]};
  assign c2  = sr[3];
  assign c1  = sr[4];
  assign c0  = sr[5];
  assign seg = sr[FRAME_W-1:CMD_W];

  logic       wr_act;
  logic [1:0] wr_addr_q, wr_addr;
  logic       wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act    <= 1'b0;
      wr_addr_q <= '0;
    end else if (ld_rise) begin
      wr_act    <= (op == OP_WRITE);
      wr_addr_q <= {c2, c1};
    end else if (!ld_s) begin
      wr_act    <= 1'b0;
    end
  end

  assign wr_en   = ld_s & (ld_rise ? (op == OP_WRITE) : wr_act);
  assign wr_addr = ld_rise ? {c2, c1} : wr_addr_q;

  logic [SEG_W-1:0] bank [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             bank[g] <= '0;
      else if (wr_en && wr_addr == 2'(g))     bank[g] <= seg;
    end
  end

  assign bank0 = bank[0];
  assign bank1 = bank[1];
  assign bank2 = bank[2];
  assign bank3 = bank[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_code <= '0;
      bias_half <= 1'b0;
      wave_b    <= 1'b0;
      duty_code <= '0;
      disp_on   <= 1'b0;
    end else if (ld_rise) begin
      case (op)
        OP_RATE:  rate_code <= {c2, c1, c0};
        OP_DRIVE: begin
          bias_half <= c2;
          wave_b    <= c1;
        end
        OP_DUTY:  duty_code <= {c2, c1};
        OP_DISP:  disp_on   <= c2;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/lcd_serial_loader_chk.sv
module lcd_serial_loader_chk #(
  parameter int SEG_W = 50
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_s,
  input logic             ld_rise,
  input logic [SEG_W+5:0] sr,
  input logic [SEG_W-1:0] bank0,
  input logic [SEG_W-1:0] bank1,
  input logic [SEG_W-1:0] bank2,
  input logic [SEG_W-1:0] bank3,
  input logic [2:0]       rate_code,
  input logic             bias_half,
  input logic             wave_b,
  input logic [1:0]       duty_code,
  input logic             disp_on
);
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable({rate_code, bias_half, wave_b, duty_code, disp_on}));

  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_s |=> $stable({bank3, bank2, bank1, bank0}));

  // R2
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({bank0 != $past(bank0), bank1 != $past(bank1),
                bank2 != $past(bank2), bank3 != $past(bank3)}) <= 1);

  // R10
  shift_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_s |=> $stable(sr));

  // R6
  disp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_on) |-> $past(ld_rise));
endmodule

bind lcd_serial_loader lcd_serial_loader_chk #(.SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_s(ld_s), .ld_rise(ld_rise), .sr(sr),
  .bank0(bank0), .bank1(bank1), .bank2(bank2), .bank3(bank3),
  .rate_code(rate_code), .bias_half(bias_half), .wave_b(wave_b),
  .duty_code(duty_code), .disp_on(disp_on)
);

// File: tb/lcd_serial_loader_tb.sv
module lcd_serial_loader_tb;
  localparam int SEG_W = 50;

  logic clk = 1'b0, rst_n = 1'b0, sd = 1'b0, sc = 1'b0, sl = 1'b0;
  logic [SEG_W-1:0] bank0, bank1, bank2, bank3;
  logic [2:0] rate_code;
  logic bias_half, wave_b, disp_on;
  logic [1:0] duty_code;

  lcd_serial_loader #(.SEG_W(SEG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_data(sd), .ser_clk(sc), .ser_load(sl),
    .bank0(bank0), .bank1(bank1), .bank2(bank2), .bank3(bank3),
    .rate_code(rate_code), .bias_half(bias_half), .wave_b(wave_b),
    .duty_code(duty_code), .disp_on(disp_on)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [SEG_W-1:0] eb [4];
  logic [2:0] e_rate;
  logic e_bias, e_wave, e_disp;
  logic [1:0] e_duty;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, "bank0", 64'(bank0), 64'(eb[0]));
    chk(req, "bank1", 64'(bank1), 64'(eb[1]));
    chk(req, "bank2", 64'(bank2), 64'(eb[2]));
    chk(req, "bank3", 64'(bank3), 64'(eb[3]));
    chk(req, "rate", 64'(rate_code), 64'(e_rate));
    chk(req, "bias", 64'(bias_half), 64'(e_bias));
    chk(req, "wave", 64'(wave_b), 64'(e_wave));
    chk(req, "duty", 64'(duty_code), 64'(e_duty));
    chk(req, "disp", 64'(disp_on), 64'(e_disp));
  endtask

  task automatic clear_exp();
    for (int i = 0; i < 4; i++) eb[i] = '0;
    e_rate = '0; e_bias = 1'b0; e_wave = 1'b0; e_duty = '0; e_disp = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sd = b; tick(3); sc = 1'b1; tick(4); sc = 1'b0; tick(3);
  endtask

  task automatic send_seg(input logic [SEG_W-1:0] s);
    for (int i = SEG_W - 1; i >= 0; i--) send_bit(s[i]);
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic c2, input logic c1, input logic c0);
    send_bit(c0); send_bit(c1); send_bit(c2);
    send_bit(op[0]); send_bit(op[1]); send_bit(op[2]);
  endtask

  task automatic pulse_load();
    sl = 1'b1; tick(8); sl = 1'b0; tick(6);
  endtask

  task automatic t_reset();
    clear_exp();
    check_state("R11");
  endtask

  task automatic t_write();
    logic [SEG_W-1:0] p [4];
    p[0] = 50'h2_A5C3_0F1E_7781;
    p[1] = 50'h1_0000_0000_0001;
    p[2] = 50'h3_FFFF_0000_FFFF;
    p[3] = 50'h2_0000_0000_0000;
    for (int a = 0; a < 4; a++) begin
      send_seg(p[a]);
      send_cmd(3'b001, a[1], a[0], 1'b0);
      pulse_load();
      eb[a] = p[a];
      check_state("R1/R2");
    end
  endtask

  task automatic t_modes();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_cmd(3'b010, 1'b1, 1'b0, 1'b1);
    pulse_load(); e_rate = 3'd5;
    check_state("R3/R8");
    send_cmd(3'b011, 1'b1, 1'b1, 1'b0);
    pulse_load(); e_bias = 1'b1; e_wave = 1'b1;
    check_state("R4/R8");
    send_cmd(3'b100, 1'b1, 1'b0, 1'b1);
    pulse_load(); e_duty = 2'd2;
    check_state("R5");
    send_cmd(3'b101, 1'b1, 1'b0, 1'b0);
    pulse_load(); e_disp = 1'b1;
    check_state("R6");
    send_cmd(3'b011, 1'b0, 1'b1, 1'b1);
    pulse_load(); e_bias = 1'b0; e_wave = 1'b1;
    check_state("R4");
  endtask

  task automatic t_ignored();
    logic [2:0] ops [3];
    ops[0] = 3'b000; ops[1] = 3'b110; ops[2] = 3'b111;
    for (int k = 0; k < 3; k++) begin
      send_seg(50'h1_5555_AAAA_3C3C);
      send_cmd(ops[k], 1'b1, 1'b1, 1'b1);
      pulse_load();
      check_state("R7");
    end
    send_seg(50'h0_F0F0_1234_ABCD);
    send_cmd(3'b010, 1'b0, 1'b1, 1'b0);
    pulse_load(); e_rate = 3'd2;
    check_state("R7");
  endtask

  task automatic t_transparent();
    logic [SEG_W-1:0] p;
    p = 50'h3_1357_9BDF_2468;
    send_seg(p);
    send_cmd(3'b001, 1'b0, 1'b1, 1'b1);
    sl = 1'b1; tick(6);
    eb[1] = p;
    check_state("R9");
    for (int i = 0; i < 8; i++) send_bit(i[0]);
    sl = 1'b0; tick(6);
    check_state("R9/R10");
    pulse_load();
    check_state("R10");
  endtask

  task automatic t_async_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; #0.5;
    clear_exp();
    check_state("R11");
    tick(3); rst_n = 1'b1; tick(2);
    check_state("R11");
  endtask

  initial begin
    clear_exp();
    tick(4);
    t_reset();
    rst_n = 1'b1;
    tick(4);
    t_write();
    t_modes();
    t_ignored();
    t_transparent();
    t_async_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule